// File: doc/BRIEF.md
# Serial Port Interrupt Status Unit

This unit produces the interrupt requests of a synchronous serial port. It observes the occupancy counts of the receive and transmit FIFOs, a strobe that marks each completely received frame, a strobe for each receive FIFO read, and a tick that marks each serial bit period. From these inputs it derives four conditions:

- receive overrun
- receive idle timeout
- receive FIFO at least half full
- transmit FIFO at least half empty

Software reaches the unit through a small register port. The port holds an enable mask, a raw view of the conditions, a masked view of the conditions, and a write-one-to-clear register for the two latched conditions. A single registered interrupt line is the OR of the enabled conditions.

The two FIFO level conditions follow the occupancy counts with one register of delay. Overrun and timeout are latched and stay set until software clears them.

Top module: `serial_irq_gen`

## Requirements
- R1: The register port has four addresses. Address 0 is the mask register (read/write). Address 1 is raw status (read-only). Address 2 is masked status (read-only). Address 3 is the clear register (write-only, reads 0). In every status, mask and clear word, bit 0 is overrun, bit 1 is timeout, bit 2 is receive half full and bit 3 is transmit half empty. Bits above 3 always read 0.
- R2: After reset the mask reads 0, the irq line is 0, and raw status reads 4'b1000 while both occupancy counts are 0.
- R3: A frame-done strobe while rx_level equals FIFO_DEPTH sets raw bit 0 at the next clock edge. The bit stays set after the level drops. A frame-done strobe at any lower level leaves the bit alone.
- R4: Writing the clear register clears raw bit 0 and raw bit 1 wherever the write data has a 1. Zero data bits have no effect. A set condition in the same cycle as a clear wins.
- R5: When rx_level is nonzero and TIMEOUT_BITS bit ticks have passed with no read strobe and no frame-done strobe, raw bit 1 is set. A read strobe, a frame-done strobe or an empty receive FIFO restarts the count. One idle stretch sets the bit only once.
- R6: Raw bit 2 equals 1 one cycle after 2*rx_level >= FIFO_DEPTH holds.
- R7: Raw bit 3 equals 1 one cycle after 2*tx_level <= FIFO_DEPTH holds.
- R8: Masked status reads raw status AND mask.
- R9: irq_o equals the OR of the masked status bits, delayed by one register.
- R10: Writes to the raw and masked status addresses have no effect. Mask write data above bit 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| tx_level | input | LVL_W | Transmit FIFO occupancy |
| rx_frame_done | input | 1 | One-cycle strobe: a frame was completely received |
| rx_pop | input | 1 | One-cycle strobe: receive FIFO was read |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, combinational from reg_addr |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the unit with FIFO_DEPTH 8 and TIMEOUT_BITS 6. The depth of 8 places the half-full and half-empty thresholds at level 4, so the walk over the vector table covers both sides of each threshold. The short timeout puts the exact tick on which the timeout fires, its restart by a read, and its one-shot behaviour within a few dozen cycles. At level 8 the overrun rule and the set-beats-clear ordering can be exercised directly.

// File: rtl/serial_irq_pkg.sv
package serial_irq_pkg;

  localparam int NUM_IRQ = 4;
  localparam int IRQ_OVR = 0;
  localparam int IRQ_TMO = 1;
  localparam int IRQ_RXH = 2;
  localparam int IRQ_TXH = 3;

  typedef enum logic [1:0] {
    REG_MASK   = 2'd0,
    REG_RAW    = 2'd1,
    REG_MASKED = 2'd2,
    REG_CLEAR  = 2'd3
  } irq_reg_e;

  // receive side: occupancy has reached half the capacity
  function automatic logic fill_reaches_half(input int unsigned fill,
                                             input int unsigned depth);
    return (fill * 2) >= depth;
  endfunction

  // transmit side: free space has reached half the capacity
  function automatic logic space_reaches_half(input int unsigned fill,
                                              input int unsigned depth);
    if (fill > depth) return 1'b0;
    return ((depth - fill) * 2) >= depth;
  endfunction

  // a latched condition only leaves on a software clear
  function automatic logic is_sticky(input int idx);
    return (idx == IRQ_OVR) || (idx == IRQ_TMO);
  endfunction

endpackage

// File: rtl/irq_rx_timer.sv
module irq_rx_timer #(
  parameter int TIMEOUT_BITS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_nonempty,
  input  logic rx_pop,
  input  logic rx_frame_done,
  input  logic bit_tick,
  output logic tmo_event
);
  localparam int CNT_W = $clog2(TIMEOUT_BITS + 1);

  logic [CNT_W-1:0] idle_cnt;
  logic             restart;
  logic             saturated;

  assign restart   = rx_pop | rx_frame_done | ~rx_nonempty;
  assign saturated = (idle_cnt == CNT_W'(TIMEOUT_BITS));
  assign tmo_event = bit_tick & ~restart & (idle_cnt == CNT_W'(TIMEOUT_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
    end else if (restart) begin
      idle_cnt <= '0;
    end else if (bit_tick && !saturated) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/irq_raw_status.sv
module irq_raw_status
  import serial_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic [LVL_W-1:0]   tx_level,
  input  logic               ovr_event,
  input  logic               tmo_event,
  input  logic [NUM_IRQ-1:0] clr_bits,
  output logic [NUM_IRQ-1:0] raw_bits
);
  logic [NUM_IRQ-1:0] set_vec;

  always_comb begin
    set_vec          = '0;
    set_vec[IRQ_OVR] = ovr_event;
    set_vec[IRQ_TMO] = tmo_event;
    set_vec[IRQ_RXH] = fill_reaches_half(32'(rx_level), FIFO_DEPTH);
    set_vec[IRQ_TXH] = space_reaches_half(32'(tx_level), FIFO_DEPTH);
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    logic bit_q;
    if (is_sticky(i)) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           bit_q <= 1'b0;
        else if (set_vec[i])  bit_q <= 1'b1;
        else if (clr_bits[i]) bit_q <= 1'b0;
      end
    end else begin : g_level
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= (i == IRQ_TXH);
        else        bit_q <= set_vec[i];
      end
    end
    assign raw_bits[i] = bit_q;
  end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import serial_irq_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         reg_addr,
  input  logic               reg_wr,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic [NUM_IRQ-1:0] raw_bits,
  output logic [NUM_IRQ-1:0] mask_bits,
  output logic [NUM_IRQ-1:0] clr_bits,
  output logic [REG_W-1:0]   reg_rdata
);
  irq_reg_e sel;
  logic     wdata_unused;

  assign sel          = irq_reg_e'(reg_addr);
  assign wdata_unused = ^reg_wdata[REG_W-1:NUM_IRQ];
  assign clr_bits     = (reg_wr && sel == REG_CLEAR) ? reg_wdata[NUM_IRQ-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         mask_bits <= '0;
    else if (reg_wr && sel == REG_MASK) mask_bits <= reg_wdata[NUM_IRQ-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      REG_MASK:   reg_rdata[NUM_IRQ-1:0] = mask_bits;
      REG_RAW:    reg_rdata[NUM_IRQ-1:0] = raw_bits;
      REG_MASKED: reg_rdata[NUM_IRQ-1:0] = raw_bits & mask_bits;
      REG_CLEAR:  reg_rdata              = '0;
      default:    reg_rdata              = '0;
    endcase
  end
endmodule

// File: rtl/serial_irq_gen.sv
module serial_irq_gen
  import serial_irq_pkg::*;
#(
  parameter int FIFO_DEPTH   = 8,
  parameter int TIMEOUT_BITS = 32,
  parameter int REG_W        = 8,
  localparam int LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             rx_frame_done,
  input  logic             rx_pop,
  input  logic             bit_tick,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_o
);
  // named internal events, also seen by the bound checker
  logic               ovr_event;
  logic               tmo_event;
  logic [NUM_IRQ-1:0] raw_bits;
  logic [NUM_IRQ-1:0] mask_bits;
  logic [NUM_IRQ-1:0] clr_bits;

  assign ovr_event = rx_frame_done & (rx_level == LVL_W'(FIFO_DEPTH));

  irq_rx_timer #(.TIMEOUT_BITS(TIMEOUT_BITS)) u_timer (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_nonempty   (rx_level != '0),
    .rx_pop        (rx_pop),
    .rx_frame_done (rx_frame_done),
    .bit_tick      (bit_tick),
    .tmo_event     (tmo_event)
  );

  irq_raw_status #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_raw (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_level  (rx_level),
    .tx_level  (tx_level),
    .ovr_event (ovr_event),
    .tmo_event (tmo_event),
    .clr_bits  (clr_bits),
    .raw_bits  (raw_bits)
  );

  irq_reg_port #(.REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .raw_bits  (raw_bits),
    .mask_bits (mask_bits),
    .clr_bits  (clr_bits),
    .reg_rdata (reg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(raw_bits & mask_bits);
  end
endmodule

// File: rtl/serial_irq_chk.sv
module serial_irq_chk #(
  parameter int FIFO_DEPTH = 8,
  parameter int LVL_W      = 4,
  parameter int REG_W      = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] tx_level,
  input logic             ovr_event,
  input logic             tmo_event,
  input logic [3:0]       raw_bits,
  input logic [3:0]       mask_bits,
  input logic [3:0]       clr_bits,
  input logic [1:0]       reg_addr,
  input logic [REG_W-1:0] reg_rdata,
  input logic             irq_o
);
  p_ovr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_event |=> raw_bits[0]);

  p_ovr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_bits[0] && !clr_bits[0]) |=> raw_bits[0]);

  p_ovr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bits[0] && !ovr_event) |=> !raw_bits[0]);

  p_tmo_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_bits[1] && !clr_bits[1]) |=> raw_bits[1]);

  p_tmo_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_bits[1]) |-> $past(tmo_event));

  p_rx_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (raw_bits[2] == ((32'($past(rx_level)) * 2) >= 32'(FIFO_DEPTH))));

  p_tx_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (raw_bits[3] == ((32'($past(tx_level)) * 2) <= 32'(FIFO_DEPTH))));

  p_masked_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2) |-> (reg_rdata == REG_W'(raw_bits & mask_bits)));

  p_clear_reads_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd3) |-> (reg_rdata == '0));

  p_irq_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(raw_bits & mask_bits))));
endmodule

bind serial_irq_gen serial_irq_chk #(
  .FIFO_DEPTH (FIFO_DEPTH),
  .LVL_W      (LVL_W),
  .REG_W      (REG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_level  (rx_level),
  .tx_level  (tx_level),
  .ovr_event (ovr_event),
  .tmo_event (tmo_event),
  .raw_bits  (raw_bits),
  .mask_bits (mask_bits),
  .clr_bits  (clr_bits),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .irq_o     (irq_o)
);

// File: tb/tb_serial_irq_gen.sv
module tb_serial_irq_gen;
  localparam int DEPTH = 8;
  localparam int TMO   = 6;
  localparam int LW    = 4;
  localparam int NVEC  = 8;
  // {rx_level, tx_level, mask}
  localparam logic [11:0] VEC [NVEC] = '{
    {4'd0, 4'd0, 4'hC}, {4'd3, 4'd5, 4'hF}, {4'd4, 4'd5, 4'h4}, {4'd4, 4'd4, 4'h8},
    {4'd8, 4'd8, 4'hC}, {4'd7, 4'd0, 4'h3}, {4'd2, 4'd6, 4'h8}, {4'd5, 4'd3, 4'h4}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [LW-1:0] rx_level = '0;
  logic [LW-1:0] tx_level = '0;
  logic          rx_frame_done = 1'b0;
  logic          rx_pop = 1'b0;
  logic          bit_tick = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          irq_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  serial_irq_gen #(.FIFO_DEPTH(DEPTH), .TIMEOUT_BITS(TMO), .REG_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
    .rx_frame_done(rx_frame_done), .rx_pop(rx_pop), .bit_tick(bit_tick),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    bit_tick = 1'b1;
    repeat (n) step();
    bit_tick = 1'b0;
  endtask

  task automatic pop_once();
    rx_pop = 1'b1;
    step();
    rx_pop = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [3:0] exp_raw;
    logic [3:0] m;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R2 reset state, R1 clear register reads zero
    rd(2'd0, d); check("R2 mask", d, 8'h00);
    rd(2'd1, d); check("R2 raw", d, 8'h08);
    rd(2'd2, d); check("R2 masked", d, 8'h00);
    check("R2 irq", irq_o, 1'b0);
    rd(2'd3, d); check("R1 clear reads 0", d, 8'h00);

    // R10 upper mask bits ignored; R9 one-cycle delay
    wr(2'd0, 8'hFF);
    rd(2'd0, d); check("R10 mask upper", d, 8'h0F);
    check("R9 irq not yet", irq_o, 1'b0);
    wr(2'd1, 8'h07);
    check("R9 irq after delay", irq_o, 1'b1);
    rd(2'd1, d); check("R10 raw write ignored", d, 8'h08);
    wr(2'd2, 8'hFF);
    rd(2'd1, d); check("R10 masked write ignored", d, 8'h08);
    wr(2'd0, 8'h00);

    // R6 R7 R8 R9 vector walk
    for (int i = 0; i < NVEC; i++) begin
      rx_level = VEC[i][11:8];
      tx_level = VEC[i][7:4];
      m        = VEC[i][3:0];
      exp_raw  = 4'b0000;
      exp_raw[2] = (int'(VEC[i][11:8]) >= DEPTH / 2);
      exp_raw[3] = (int'(VEC[i][7:4]) <= DEPTH - DEPTH / 2);
      wr(2'd0, {4'b0, m});
      rd(2'd1, d); check($sformatf("R6/R7 raw vec%0d", i), d, {4'b0, exp_raw});
      rd(2'd2, d); check($sformatf("R8 masked vec%0d", i), d, {4'b0, exp_raw & m});
      step();
      check($sformatf("R9 irq vec%0d", i), irq_o, |(exp_raw & m));
    end
    wr(2'd0, 8'h00);
    tx_level = '0;

    // R3 overrun
    rx_level = 4'd7;
    rx_frame_done = 1'b1; step(); rx_frame_done = 1'b0;
    rd(2'd1, d); check("R3 no overrun below full", d[0], 1'b0);
    rx_level = 4'd8;
    rx_frame_done = 1'b1; step(); rx_frame_done = 1'b0;
    rd(2'd1, d); check("R3 overrun at full", d[0], 1'b1);
    rx_level = 4'd3; step();
    rd(2'd1, d); check("R3 overrun sticky", d[0], 1'b1);

    // R4 clear
    wr(2'd3, 8'h02);
    rd(2'd1, d); check("R4 zero bit no effect", d[0], 1'b1);
    wr(2'd3, 8'h01);
    rd(2'd1, d); check("R4 clear overrun", d[0], 1'b0);
    rx_level = 4'd8; rx_frame_done = 1'b1;
    wr(2'd3, 8'h01);
    rx_frame_done = 1'b0;
    rd(2'd1, d); check("R4 set beats clear", d[0], 1'b1);
    rx_level = 4'd3;
    wr(2'd3, 8'h01);

    // R5 timeout
    pop_once();
    ticks(TMO - 1);
    rd(2'd1, d); check("R5 not before period", d[1], 1'b0);
    ticks(1);
    rd(2'd1, d); check("R5 fires at period", d[1], 1'b1);
    wr(2'd3, 8'h02);
    rd(2'd1, d); check("R4 clear timeout", d[1], 1'b0);
    ticks(TMO + 2);
    rd(2'd1, d); check("R5 fires once", d[1], 1'b0);
    pop_once();
    ticks(TMO - 2);
    pop_once();
    ticks(TMO - 1);
    rd(2'd1, d); check("R5 read restarts", d[1], 1'b0);
    ticks(1);
    rd(2'd1, d); check("R5 fires after restart", d[1], 1'b1);
    wr(2'd3, 8'h02);
    rx_frame_done = 1'b1; step(); rx_frame_done = 1'b0;
    ticks(TMO - 1);
    rd(2'd1, d); check("R5 frame restarts", d[1], 1'b0);
    rx_level = 4'd0;
    ticks(2 * TMO);
    rd(2'd1, d); check("R5 empty never times out", d[1], 1'b0);

    // R9 irq from timeout
    rx_level = 4'd3;
    wr(2'd0, 8'h02);
    pop_once();
    ticks(TMO);
    check("R9 irq lags raw", irq_o, 1'b0);
    step();
    check("R9 irq on timeout", irq_o, 1'b1);
    wr(2'd3, 8'h02);
    check("R9 irq lags clear", irq_o, 1'b1);
    step();
    check("R9 irq drops", irq_o, 1'b0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule